// File: doc/BRIEF.md
# Fan Tachometer Period Measurement Engine

This block measures the period of a fan's tachometer signal on request. Several tach inputs share one measurement engine. A write to the trigger port, with exactly one bit set at the channel index, selects that channel and starts a measurement. The engine samples the chosen input through a synchroniser and looks for the configured edge type. It counts prescaled clock ticks between two qualifying edges, then publishes the tick count together with a done flag.

The counting clock is the system clock divided by `4 << (2 × clkDiv)`. A measurement window of `measUnit` ticks limits how long the engine waits. A fan that stalls, or that never shows a qualifying edge, produces a completed result with a count of zero. Higher layers poll `resultDone` and turn the count into a speed. In both-edges mode the count covers half a fan revolution, so software doubles the divisor for that mode.

Top module: `tach_meas_unit`

## Requirements
- R1: After reset `resultDone` is 0 and `resultCount` is 0.
- R2: Every trigger write clears `resultDone` and `resultCount` to 0 on the capturing clock. A trigger write starts a measurement when `trigData` has exactly one bit set and the `chanEnable` bit at that index is 1.
- R3: A trigger write with `trigData` equal to zero, with more than one bit set, or naming a channel whose `chanEnable` bit is 0 starts nothing. Such a write also aborts a measurement in progress. `resultDone` and `resultCount` then stay 0 until the next trigger write.
- R4: `edgeMode` selects which edges qualify on the selected input: 2'b00 falling, 2'b01 rising, 2'b10 both. The first qualifying edge arms the count and the second ends it. The count equals floor((D−1)/P), where D is the number of clock cycles between the two edges.
- R5: The tick divisor P is 4 << (2 × `clkDiv`), which gives 4, 16, 64 and 256 for `clkDiv` values 0 to 3.
- R6: `resultDone` is 0 while a measurement runs and rises together with the published count. A published count of 0 is a valid result.
- R7: When the window of max(`measUnit`,1) ticks, counted from the capturing clock, expires before the measurement completes, the engine completes with count 0. With no qualifying edge this happens P × max(`measUnit`,1) cycles after the capturing clock.
- R8: `edgeMode` 2'b11 is reserved and no edge qualifies in it, so every measurement ends through the window with count 0.
- R9: A published result, both flag and count, holds unchanged until the next trigger write.
- R10: Only the input whose trigger bit was set affects the measurement. Activity on other channels changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tachIn | input | NUM_CH | Raw tachometer inputs, one per channel |
| chanEnable | input | NUM_CH | Per-channel enable for starting a measurement |
| trigWrite | input | 1 | Strobe: trigger port written this cycle |
| trigData | input | NUM_CH | Trigger value, one-hot channel select |
| edgeMode | input | 2 | Qualifying edge select (falling/rising/both/reserved) |
| clkDiv | input | DIV_W | Tick prescaler exponent |
| measUnit | input | UNIT_W | Measurement window length in ticks |
| resultCount | output | COUNT_W | Measured tick count |
| resultDone | output | 1 | Result valid flag |

## Verification
The trigger is captured on one rising edge. The flag clears on that same edge, so it reads 0 at the next falling edge. An input transition reaches the edge detector three clocks after it is sampled: two synchroniser stages, then the previous-value register. The count is published on the clock that sees the second qualifying edge. A stalled fan completes exactly P × max(`measUnit`,1) clocks after capture. A behavioural model in the bench keeps its own three-deep history queue of sampled inputs and its own tick phase. It predicts flag and count for every edge, and the outputs are compared at each falling edge. Directed checks also compare the hand-derived floor((D−1)/P) values and the exact timeout latency.

// File: rtl/tach_meas_pkg.sv
package tach_meas_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_COUNT = 2'd2
  } tachState_e;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RSVD = 2'b11
  } edgeMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic run;       // a measurement is in progress
    logic start;     // latch channel, clear counters
    logic clearRes;  // clear published result
    logic armTicks;  // first edge seen: restart phase and tick count
    logic incTicks;  // add one tick to the count
    logic pubCount;  // publish the tick count
    logic pubZero;   // publish a zero count (window expired)
  } tachStrobe_t;

endpackage

// File: rtl/tach_meas_ctrl.sv
module tach_meas_ctrl
  import tach_meas_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigWrite,
  input  logic        trigValid,
  input  logic        qualEdge,
  input  logic        tick,
  input  logic        winExpire,
  output tachStrobe_t strobe,
  output logic        busy
);

  tachState_e state, stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stNext;
  end

  always_comb begin
    stNext     = state;
    strobe     = '0;
    strobe.run = (state != ST_IDLE);
    if (trigWrite) begin
      strobe.clearRes = 1'b1;
      if (trigValid) begin
        strobe.start = 1'b1;
        stNext       = ST_ARM;
      end else begin
        stNext = ST_IDLE;
      end
    end else begin
      case (state)
        ST_ARM: begin
          // expiry beats a coincident arming edge
          if (winExpire) begin
            strobe.pubZero = 1'b1;
            stNext         = ST_IDLE;
          end else if (qualEdge) begin
            strobe.armTicks = 1'b1;
            stNext          = ST_COUNT;
          end
        end
        ST_COUNT: begin
          // closing edge beats a coincident expiry
          if (qualEdge) begin
            strobe.pubCount = 1'b1;
            stNext          = ST_IDLE;
          end else if (winExpire) begin
            strobe.pubZero = 1'b1;
            stNext         = ST_IDLE;
          end else if (tick) begin
            strobe.incTicks = 1'b1;
          end
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  assign busy = strobe.run;

endmodule

// File: rtl/tach_meas_dp.sv
module tach_meas_dp
  import tach_meas_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int COUNT_W = 20,
  parameter int UNIT_W  = 16,
  parameter int DIV_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CH-1:0]  tachIn,
  input  logic [NUM_CH-1:0]  chanEnable,
  input  logic [NUM_CH-1:0]  trigData,
  input  logic [1:0]         edgeMode,
  input  logic [DIV_W-1:0]   clkDiv,
  input  logic [UNIT_W-1:0]  measUnit,
  input  tachStrobe_t        strobe,
  output logic               trigValid,
  output logic               qualEdge,
  output logic               tick,
  output logic               winExpire,
  output logic [COUNT_W-1:0] resultCount,
  output logic               resultDone
);

  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int PRE_W = 2 + 2 * ((1 << DIV_W) - 1);
  localparam logic [PRE_W:0]    PRE_ONE = (PRE_W+1)'(1);
  localparam logic [PRE_W:0]    PRE_BASE = (PRE_W+1)'(4);
  localparam logic [UNIT_W:0]   WIN_ONE = (UNIT_W+1)'(1);
  localparam logic [COUNT_W-1:0] CNT_ONE = COUNT_W'(1);

  // per-channel synchroniser and previous-value history
  logic [NUM_CH-1:0] syncB, prevB;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sync
    logic stA, stB, stP;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stA <= 1'b0;
        stB <= 1'b0;
        stP <= 1'b0;
      end else begin
        stA <= tachIn[g];
        stB <= stA;
        stP <= stB;
      end
    end
    assign syncB[g] = stB;
    assign prevB[g] = stP;
  end

  // trigger decode
  logic [SEL_W-1:0] trigIdx, selCh;

  always_comb begin
    trigIdx = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (trigData[i]) trigIdx = SEL_W'(i);
  end

  assign trigValid = $onehot(trigData) && (|(trigData & chanEnable));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             selCh <= '0;
    else if (strobe.start) selCh <= trigIdx;
  end

  // edge qualification on the selected channel
  logic curLvl, prvLvl;
  assign curLvl = syncB[selCh];
  assign prvLvl = prevB[selCh];

  always_comb begin
    case (edgeMode_e'(edgeMode))
      EDGE_FALL: qualEdge = prvLvl & ~curLvl;
      EDGE_RISE: qualEdge = curLvl & ~prvLvl;
      EDGE_BOTH: qualEdge = curLvl ^ prvLvl;
      default:   qualEdge = 1'b0;
    endcase
  end

  // prescaler: one tick every 4 << (2*clkDiv) cycles
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W:0]   preDiv;

  assign preDiv = PRE_BASE << {clkDiv, 1'b0};
  assign tick   = strobe.run && ({1'b0, preCnt} == (preDiv - PRE_ONE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               preCnt <= '0;
    else if (strobe.start || strobe.armTicks) preCnt <= '0;
    else if (strobe.run)                      preCnt <= tick ? '0 : preCnt + PRE_ONE[PRE_W-1:0];
  end

  // measurement window in ticks
  logic [UNIT_W:0] winCnt, winLimit;

  assign winLimit  = (measUnit == '0) ? WIN_ONE : {1'b0, measUnit};
  assign winExpire = tick && ((winCnt + WIN_ONE) >= winLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             winCnt <= '0;
    else if (strobe.start) winCnt <= '0;
    else if (tick)         winCnt <= winCnt + WIN_ONE;
  end

  // tick counter between the two qualifying edges
  logic [COUNT_W-1:0] tickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                tickCnt <= '0;
    else if (strobe.start || strobe.armTicks) tickCnt <= '0;
    else if (strobe.incTicks)                 tickCnt <= tickCnt + CNT_ONE;
  end

  // published result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultCount <= '0;
      resultDone  <= 1'b0;
    end else if (strobe.clearRes) begin
      resultCount <= '0;
      resultDone  <= 1'b0;
    end else if (strobe.pubCount) begin
      resultCount <= tickCnt;
      resultDone  <= 1'b1;
    end else if (strobe.pubZero) begin
      resultCount <= '0;
      resultDone  <= 1'b1;
    end
  end

endmodule

// File: rtl/tach_meas_unit.sv
module tach_meas_unit
  import tach_meas_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int COUNT_W = 20,
  parameter int UNIT_W  = 16,
  parameter int DIV_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CH-1:0]  tachIn,
  input  logic [NUM_CH-1:0]  chanEnable,
  input  logic               trigWrite,
  input  logic [NUM_CH-1:0]  trigData,
  input  logic [1:0]         edgeMode,
  input  logic [DIV_W-1:0]   clkDiv,
  input  logic [UNIT_W-1:0]  measUnit,
  output logic [COUNT_W-1:0] resultCount,
  output logic               resultDone
);

  tachStrobe_t strobe;
  logic trigValid, qualEdge, tick, winExpire, engineBusy;

  tach_meas_dp #(
    .NUM_CH (NUM_CH),
    .COUNT_W(COUNT_W),
    .UNIT_W (UNIT_W),
    .DIV_W  (DIV_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tachIn     (tachIn),
    .chanEnable (chanEnable),
    .trigData   (trigData),
    .edgeMode   (edgeMode),
    .clkDiv     (clkDiv),
    .measUnit   (measUnit),
    .strobe     (strobe),
    .trigValid  (trigValid),
    .qualEdge   (qualEdge),
    .tick       (tick),
    .winExpire  (winExpire),
    .resultCount(resultCount),
    .resultDone (resultDone)
  );

  tach_meas_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .trigWrite(trigWrite),
    .trigValid(trigValid),
    .qualEdge (qualEdge),
    .tick     (tick),
    .winExpire(winExpire),
    .strobe   (strobe),
    .busy     (engineBusy)
  );

endmodule

// File: rtl/tach_meas_chk.sv
module tach_meas_chk #(
  parameter int NUM_CH  = 16,
  parameter int COUNT_W = 20
) (
  input logic               clk,
  input logic               rstN,
  input logic               trigWrite,
  input logic [NUM_CH-1:0]  trigData,
  input logic [NUM_CH-1:0]  chanEnable,
  input logic               resultDone,
  input logic [COUNT_W-1:0] resultCount,
  input logic               engineBusy
);

  // R2
  trig_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigWrite |=> !resultDone);

  // R3
  bad_trig_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigWrite && !($onehot(trigData) && (|(trigData & chanEnable)))) |=> !engineBusy);

  // R6
  busy_not_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    engineBusy |-> !resultDone);

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resultDone |-> (resultCount == '0));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultDone && !trigWrite) |=> (resultDone && $stable(resultCount)));

endmodule

bind tach_meas_unit tach_meas_chk #(
  .NUM_CH (NUM_CH),
  .COUNT_W(COUNT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .trigWrite  (trigWrite),
  .trigData   (trigData),
  .chanEnable (chanEnable),
  .resultDone (resultDone),
  .resultCount(resultCount),
  .engineBusy (engineBusy)
);

// File: tb/tach_meas_unit_bench.sv
module tach_meas_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH  = 16;
  localparam int COUNT_W = 20;
  localparam int UNIT_W  = 16;
  localparam int DIV_W   = 2;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_CH-1:0]  tachIn = '0;
  logic [NUM_CH-1:0]  chanEnable = '0;
  logic               trigWrite = 1'b0;
  logic [NUM_CH-1:0]  trigData = '0;
  logic [1:0]         edgeMode = 2'b01;
  logic [DIV_W-1:0]   clkDiv = '0;
  logic [UNIT_W-1:0]  measUnit = '0;
  logic [COUNT_W-1:0] resultCount;
  logic               resultDone;

  tach_meas_unit #(
    .NUM_CH(NUM_CH), .COUNT_W(COUNT_W), .UNIT_W(UNIT_W), .DIV_W(DIV_W)
  ) u_tach_meas_unit (
    .clk(clk), .rstN(rstN), .tachIn(tachIn), .chanEnable(chanEnable),
    .trigWrite(trigWrite), .trigData(trigData), .edgeMode(edgeMode),
    .clkDiv(clkDiv), .measUnit(measUnit),
    .resultCount(resultCount), .resultDone(resultDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    nChecks = 0;
  int    nFail = 0;
  string curReq = "R1";

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // tach stimulus: square waves with per-channel half period
  int halfPer[NUM_CH];
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < NUM_CH; i++)
      tachIn[i] = (halfPer[i] == 0) ? 1'b0 : 1'(((cyc / halfPer[i]) % 2));
  end

  // behavioural reference model
  logic [NUM_CH-1:0] hist[$];
  int mState = 0, mPhase = 0, mWin = 0, mTicks = 0, mCh = 0;
  bit expDone = 0;
  int expCount = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      hist = {'0, '0, '0};
      mState = 0; expDone = 0; expCount = 0;
    end else begin
      bit cur, prv, q, tk, ex;
      int p, lim;
      cur = hist[1][mCh];
      prv = hist[2][mCh];
      case (edgeMode)
        2'b00: q = prv && !cur;
        2'b01: q = cur && !prv;
        2'b10: q = cur != prv;
        default: q = 0;
      endcase
      if (trigWrite) begin
        expDone = 0; expCount = 0;
        if ($countones(trigData) == 1 && (trigData & chanEnable) != 0) begin
          mState = 1; mPhase = 0; mWin = 0; mTicks = 0;
          for (int i = 0; i < NUM_CH; i++) if (trigData[i]) mCh = i;
        end else mState = 0;
      end else if (mState != 0) begin
        p = 4 << (2 * int'(clkDiv));
        lim = (measUnit == 0) ? 1 : int'(measUnit);
        mPhase++;
        tk = (mPhase == p);
        if (tk) begin mPhase = 0; mWin++; end
        ex = tk && (mWin >= lim);
        if (mState == 1) begin
          if (ex) begin expDone = 1; expCount = 0; mState = 0; end
          else if (q) begin mState = 2; mTicks = 0; mPhase = 0; end
        end else begin
          if (q) begin expDone = 1; expCount = mTicks; mState = 0; end
          else if (ex) begin expDone = 1; expCount = 0; mState = 0; end
          else if (tk) mTicks++;
        end
      end
      hist.push_front(tachIn);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk(resultDone == expDone, {curReq, " model flag"}, resultDone, expDone);
      chk(int'(resultCount) == expCount, {curReq, " model count"}, resultCount, expCount);
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic trig(input logic [NUM_CH-1:0] d);
    @(negedge clk);
    trigWrite = 1'b1; trigData = d;
    @(negedge clk);
    trigWrite = 1'b0; trigData = '0;
  endtask

  task automatic waitDone(input int maxc, output int n);
    n = 0;
    while (!resultDone && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(input int ch, input int expect_, input string tag);
    int n;
    curReq = tag;
    trig(NUM_CH'(1) << ch);
    chk(resultDone == 1'b0, {tag, " flag low while running"}, resultDone, 0);
    waitDone(5000, n);
    chk(resultDone == 1'b1, {tag, " completes"}, resultDone, 1);
    chk(int'(resultCount) == expect_, {tag, " count"}, resultCount, expect_);
  endtask

  initial begin
    int n;
    for (int i = 0; i < NUM_CH; i++) halfPer[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(resultDone == 1'b0, "R1 flag after reset", resultDone, 0);
    chk(resultCount == '0, "R1 count after reset", resultCount, 0);

    halfPer[3] = 20; halfPer[10] = 50; halfPer[5] = 15; halfPer[12] = 150;
    chanEnable = 16'hFFDF;   // channel 5 disabled
    measUnit = 16'd1000;
    repeat (5) @(negedge clk);

    edgeMode = 2'b01; clkDiv = 2'd0;
    measure(3, 9, "R4 rising ch3");
    measure(10, 24, "R10 rising ch10");
    edgeMode = 2'b00;
    measure(3, 9, "R4 falling ch3");
    edgeMode = 2'b10;
    measure(3, 4, "R4 both ch3");
    edgeMode = 2'b01; clkDiv = 2'd1;
    measure(10, 6, "R5 div1 ch10");
    clkDiv = 2'd2;
    measure(12, 4, "R5 div2 ch12");
    edgeMode = 2'b10; clkDiv = 2'd3;
    measure(12, 0, "R6 zero count ch12");

    // R9: result holds
    curReq = "R9";
    begin
      logic [COUNT_W-1:0] held;
      edgeMode = 2'b01; clkDiv = 2'd0;
      measure(10, 24, "R9 setup");
      held = resultCount;
      repeat (150) @(negedge clk);
      chk(resultDone == 1'b1, "R9 flag held", resultDone, 1);
      chk(resultCount == held, "R9 count held", resultCount, held);
      // R2: new trigger clears
      curReq = "R2";
      trig(NUM_CH'(1) << 3);
      chk(resultDone == 1'b0, "R2 trigger clears flag", resultDone, 0);
      chk(resultCount == '0, "R2 trigger clears count", resultCount, 0);
      waitDone(5000, n);
    end

    // R7: timeout on a silent channel
    curReq = "R7";
    measUnit = 16'd5;
    trig(NUM_CH'(1));
    waitDone(5000, n);
    chk(n == 20, "R7 timeout latency", n, 20);
    chk(resultDone && resultCount == '0, "R7 timeout count", resultCount, 0);
    measUnit = 16'd0;
    trig(NUM_CH'(1));
    waitDone(5000, n);
    chk(n == 4, "R7 zero window latency", n, 4);

    // R8: reserved mode never qualifies
    curReq = "R8";
    edgeMode = 2'b11; measUnit = 16'd30;
    trig(NUM_CH'(1) << 3);
    waitDone(5000, n);
    chk(n == 120, "R8 reserved mode latency", n, 120);
    chk(resultDone && resultCount == '0, "R8 reserved mode count", resultCount, 0);

    // R3: invalid triggers and abort
    curReq = "R3";
    edgeMode = 2'b01; measUnit = 16'd1000;
    trig(NUM_CH'(1) << 5);
    repeat (300) @(negedge clk);
    chk(resultDone == 1'b0, "R3 disabled channel", resultDone, 0);
    trig(16'h0009);
    repeat (300) @(negedge clk);
    chk(resultDone == 1'b0, "R3 multi-bit trigger", resultDone, 0);
    trig(NUM_CH'(1) << 10);
    repeat (30) @(negedge clk);
    trig('0);
    repeat (400) @(negedge clk);
    chk(resultDone == 1'b0, "R3 zero write aborts", resultDone, 0);
    chk(resultCount == '0, "R3 count stays zero", resultCount, 0);

    finishRun();
  end

endmodule